// File: doc/BRIEF.md
# Prescaled Timer with Capture and Match Channels

This block is a 32-bit timer/counter with a 32-bit prescaler, one capture input and four match channels. In timer mode the prescaler divides the clock. In counter mode it divides the count of selected edges on the capture input. The timer moves one step each time the prescale counter wraps.

Each match channel compares the timer with its own match value. When the timer steps onto that value, the channel can raise a flag, stop the timer, arrange for the timer to return to zero on the following step, and drive its output pin low, high or toggled. The capture channel synchronises its input, loads the timer value into a capture register on a selected edge, and can clear the timer and prescaler on another edge. Clearing on the rising edge and capturing on the falling edge gives the width of a pulse directly.

A flat register port with a single-cycle write and a combinational read holds the configuration. The interrupt line is the OR of five write-1-to-clear flags.

Top module: `tmr_capmatch`

## Requirements
- R1: Register map, by word address: 0 control, 1 prescale limit, 2 prescale count (read), 3 timer count (read), 4 capture config, 5 capture value (read), 6 flags, 7 match control, 8+i match value i. Control bits are: bit0 run, bit1 hold, bit2 counter mode, bits 4:3 counter edge select. Every 2-bit edge select uses the same code: 0 none, 1 rising, 2 falling, 3 both.
- R2: With run set and hold clear, in timer mode, the prescale count rises by one per clock. When it reaches the limit P it wraps to 0 and the timer steps. After N clocks from a zero start, the timer reads N/(P+1) and the prescale count reads N mod (P+1).
- R3: While hold is set, the timer and the prescale count are forced to 0, even with run set. With run clear, neither moves.
- R4: In counter mode, the prescaler steps once per capture-input edge of the selected kind (rising, falling or both), instead of once per clock.
- R5: The capture input passes through two synchronising flops and an edge detector. Capture config bits 1:0 select the capture edge, and bit 2 enables the capture flag. On a capture edge, the capture value loads the timer value. A rising input seen before clock edge A is captured at edge A+2.
- R6: Capture config bits 4:3 select a clear edge. On that edge the timer and prescaler go to 0, and the clear overrides a step in the same cycle. With a zero prescale limit, clearing on the rising edge and capturing on the falling edge of a W-cycle pulse yields W-1.
- R7: Match control gives channel i the 5 bits starting at 5*i: +0 flag enable, +1 reset, +2 stop, +4:+3 output action. A match event occurs when the timer steps onto match value i. It sets flag bit i only when flag enable is set.
- R8: With reset enabled, the step after a match goes to 0, so a match value M gives a period of M+1 steps.
- R9: With stop enabled, a match clears the run bit. The timer then holds the matched value and the prescale count reads 0.
- R10: On a match event the output action code applies: 0 keeps the pin, 1 drives it low, 2 drives it high, 3 toggles it. All pins reset to 0.
- R11: Flags register bits 3:0 are the match flags and bit 4 is the capture flag. Writing 1 to a bit clears it, and a set in the same cycle wins. The irq output is high exactly when any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cap_in | input | 1 | Asynchronous capture / count input |
| match_out | output | 4 | Match-driven output pins |
| irq | output | 1 | OR of all flags |

## Verification
The bench sweeps prescale limits 0 to 3 across many run lengths, so an off-by-one in the wrap compare shows up as a drifting count. It sweeps match values with reset-on-match, so a design that returns to zero on the matching step instead of the step after it gives a period of M rather than M+1. Pulse widths 2 to 10 are measured with clear-on-rise and capture-on-fall, which exposes a wrong synchroniser depth or a clear that loses to the step. Counter mode is tried with every edge selection, and the stop and output-action cases catch a channel whose action reaches the wrong pin or never clears the run bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_KEEP   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } mact_e;

  localparam int ADR_CTRL   = 0;
  localparam int ADR_PLIM   = 1;
  localparam int ADR_PCNT   = 2;
  localparam int ADR_TCNT   = 3;
  localparam int ADR_CAPCFG = 4;
  localparam int ADR_CAPVAL = 5;
  localparam int ADR_FLAGS  = 6;
  localparam int ADR_MCTL   = 7;
  localparam int ADR_MVAL0  = 8;

  localparam int CH_BITS = 5;

  // edge select code: bit0 accepts rising, bit1 accepts falling
  function automatic logic edge_pick(input logic [1:0] sel, input logic rise,
                                     input logic fall);
    return (sel[0] & rise) | (sel[1] & fall);
  endfunction
endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic s1_q, s2_q, prev_q;
  logic s1_d, s2_d, prev_d;

  always_comb begin
    s1_d   = din;
    s2_d   = s1_q;
    prev_d = s2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= s1_d;
      s2_q   <= s2_d;
      prev_q <= prev_d;
    end
  end

  assign rise = s2_q & ~prev_q;
  assign fall = ~s2_q & prev_q;

  assert_single_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          step,
  input  logic [PW-1:0] limit,
  output logic [PW-1:0] count,
  output logic          tick
);
  logic [PW-1:0] cnt_q, cnt_d;

  assign tick = step & ~clr & (cnt_q >= limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  assert_pc_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);
  assert_pc_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt_q == '0);
endmodule

// File: rtl/tmr_match_ch.sv
module tmr_match_ch
  import tmr_pkg::*;
#(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step,
  input  logic [TW-1:0] tc_next,
  input  logic [TW-1:0] mval,
  input  mact_e         act,
  output logic          evt,
  output logic          pin
);
  logic pin_q, pin_d;

  assign evt = step & (tc_next == mval);

  always_comb begin
    pin_d = pin_q;
    if (evt) begin
      case (act)
        ACT_LOW:    pin_d = 1'b0;
        ACT_HIGH:   pin_d = 1'b1;
        ACT_TOGGLE: pin_d = ~pin_q;
        default:    pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin = pin_q;

  assert_toggle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && act == ACT_TOGGLE) |=> pin_q != $past(pin_q));
  assert_drive_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && act == ACT_HIGH) |=> pin_q);
  assert_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !evt |=> $stable(pin_q));
endmodule

// File: rtl/tmr_capmatch.sv
module tmr_capmatch
  import tmr_pkg::*;
#(
  parameter int TW   = 32,
  parameter int N_CH = 4,
  parameter int AW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [AW-1:0]   bus_addr,
  input  logic [TW-1:0]   bus_wdata,
  output logic [TW-1:0]   bus_rdata,
  input  logic            cap_in,
  output logic [N_CH-1:0] match_out,
  output logic            irq
);
  localparam int MCW = CH_BITS * N_CH;
  localparam int FW  = N_CH + 1;

  // configuration registers
  logic          run_q, run_d, hold_q, hold_d, mode_q, mode_d;
  logic [1:0]    csel_q, csel_d;
  logic [TW-1:0] plim_q, plim_d;
  logic [4:0]    capcfg_q, capcfg_d;
  logic [MCW-1:0] mctl_q, mctl_d;
  logic [TW-1:0] mval_q [N_CH];
  logic [TW-1:0] mval_d [N_CH];
  // state
  logic [TW-1:0] tc_q, tc_d, tc_next;
  logic [TW-1:0] cap_q, cap_d;
  logic [FW-1:0] flags_q, flags_d, flag_set, flag_clr;

  logic wr_ctrl, wr_plim, wr_capcfg, wr_flags, wr_mctl;
  logic in_rise, in_fall, cnt_edge, cap_evt, cap_clr;
  logic pre_step, pre_clr, tc_tick, any_rst;
  logic [TW-1:0] pcount;
  logic [N_CH-1:0] m_evt, irq_en, rst_en, stop_en;
  mact_e act [N_CH];

  assign wr_ctrl    = bus_wr && bus_addr == AW'(ADR_CTRL);
  assign wr_plim    = bus_wr && bus_addr == AW'(ADR_PLIM);
  assign wr_capcfg  = bus_wr && bus_addr == AW'(ADR_CAPCFG);
  assign wr_flags   = bus_wr && bus_addr == AW'(ADR_FLAGS);
  assign wr_mctl    = bus_wr && bus_addr == AW'(ADR_MCTL);

  tmr_edge_sync u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (cap_in),
    .rise (in_rise),
    .fall (in_fall)
  );

  assign cnt_edge = edge_pick(csel_q, in_rise, in_fall);
  assign cap_evt  = edge_pick(capcfg_q[1:0], in_rise, in_fall);
  assign cap_clr  = edge_pick(capcfg_q[4:3], in_rise, in_fall);
  assign pre_step = run_q & ~hold_q & (mode_q ? cnt_edge : 1'b1);
  assign pre_clr  = hold_q | cap_clr;

  tmr_prescale #(.PW(TW)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (pre_clr),
    .step (pre_step),
    .limit(plim_q),
    .count(pcount),
    .tick (tc_tick)
  );

  // per-channel control fields and match logic
  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    assign irq_en[i]  = mctl_q[CH_BITS*i];
    assign rst_en[i]  = mctl_q[CH_BITS*i+1];
    assign stop_en[i] = mctl_q[CH_BITS*i+2];
    assign act[i]     = mact_e'(mctl_q[CH_BITS*i+3 +: 2]);

    tmr_match_ch #(.TW(TW)) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (tc_tick),
      .tc_next(tc_next),
      .mval   (mval_q[i]),
      .act    (act[i]),
      .evt    (m_evt[i]),
      .pin    (match_out[i])
    );

    always_comb begin
      mval_d[i] = mval_q[i];
      if (bus_wr && bus_addr == AW'(ADR_MVAL0 + i)) mval_d[i] = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mval_q[i] <= '0;
      else        mval_q[i] <= mval_d[i];
    end

    assert_match_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (m_evt[i] && irq_en[i]) |=> flags_q[i]);
  end

  // reset-on-match looks at the value currently held
  always_comb begin
    any_rst = 1'b0;
    for (int i = 0; i < N_CH; i++)
      if (rst_en[i] && tc_q == mval_q[i]) any_rst = 1'b1;
  end

  assign tc_next = any_rst ? '0 : tc_q + 1'b1;

  always_comb begin
    tc_d = tc_q;
    if (hold_q)       tc_d = '0;
    else if (cap_clr) tc_d = '0;
    else if (tc_tick) tc_d = tc_next;
  end

  assign cap_d = cap_evt ? tc_q : cap_q;

  // control register: software write beats stop-on-match
  always_comb begin
    run_d  = run_q;
    hold_d = hold_q;
    mode_d = mode_q;
    csel_d = csel_q;
    if (wr_ctrl) begin
      run_d  = bus_wdata[0];
      hold_d = bus_wdata[1];
      mode_d = bus_wdata[2];
      csel_d = bus_wdata[4:3];
    end else if (|(m_evt & stop_en)) begin
      run_d = 1'b0;
    end
  end

  assign plim_d   = wr_plim   ? bus_wdata         : plim_q;
  assign capcfg_d = wr_capcfg ? bus_wdata[4:0]    : capcfg_q;
  assign mctl_d   = wr_mctl   ? bus_wdata[MCW-1:0] : mctl_q;

  assign flag_set = {cap_evt & capcfg_q[2], m_evt & irq_en};
  assign flag_clr = wr_flags ? bus_wdata[FW-1:0] : '0;
  assign flags_d  = (flags_q & ~flag_clr) | flag_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      hold_q   <= 1'b0;
      mode_q   <= 1'b0;
      csel_q   <= 2'd0;
      plim_q   <= '0;
      capcfg_q <= '0;
      mctl_q   <= '0;
      tc_q     <= '0;
      cap_q    <= '0;
      flags_q  <= '0;
    end else begin
      run_q    <= run_d;
      hold_q   <= hold_d;
      mode_q   <= mode_d;
      csel_q   <= csel_d;
      plim_q   <= plim_d;
      capcfg_q <= capcfg_d;
      mctl_q   <= mctl_d;
      tc_q     <= tc_d;
      cap_q    <= cap_d;
      flags_q  <= flags_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (int'(bus_addr))
      ADR_CTRL:   bus_rdata = TW'({csel_q, mode_q, hold_q, run_q});
      ADR_PLIM:   bus_rdata = plim_q;
      ADR_PCNT:   bus_rdata = pcount;
      ADR_TCNT:   bus_rdata = tc_q;
      ADR_CAPCFG: bus_rdata = TW'(capcfg_q);
      ADR_CAPVAL: bus_rdata = cap_q;
      ADR_FLAGS:  bus_rdata = TW'(flags_q);
      ADR_MCTL:   bus_rdata = TW'(mctl_q);
      default: begin
        for (int i = 0; i < N_CH; i++)
          if (int'(bus_addr) == ADR_MVAL0 + i) bus_rdata = mval_q[i];
      end
    endcase
  end

  assign irq = |flags_q;

  assert_stop_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|(m_evt & stop_en) && !wr_ctrl) |=> !run_q);
  assert_hold_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> tc_q == '0);
  assert_cap_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> cap_q == $past(tc_q));
  assert_tc_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tc_tick && !hold_q && !cap_clr) |=> $stable(tc_q));
endmodule

// File: tb/tmr_capmatch_bench.sv
`timescale 1ns/1ps
module tmr_capmatch_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cap_in = 1'b0;
  logic [3:0]  match_out;
  logic        irq;
  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tmr_capmatch u_tmr_capmatch (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .match_out(match_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    bus_addr = 4'(a);
    #1;
    v = bus_rdata;
  endtask

  task automatic restart(input int p);
    wr(0, 32'h2);
    wr(0, 32'h0);
    wr(1, 32'(p));
    wr(6, 32'h1F);
  endtask

  task automatic pulse(input int hi, input int lo);
    cap_in = 1'b1;
    repeat (hi) @(negedge clk);
    cap_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] o0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R1, R10, R11)
    rd(0, v); chk("R1 ctrl reset", v, 0);
    rd(3, v); chk("R1 timer reset", v, 0);
    chk("R10 pins reset", 32'(match_out), 0);
    chk("R11 irq reset", 32'(irq), 0);

    // prescale sweep (R2)
    for (int p = 0; p < 4; p++)
      for (int n = 0; n < 10; n++) begin
        restart(p);
        wr(0, 32'h1);
        repeat (n) @(negedge clk);
        rd(3, v); chk("R2 timer count", v, 32'(n / (p + 1)));
        rd(2, v); chk("R2 prescale count", v, 32'(n % (p + 1)));
      end

    // hold and run (R3)
    restart(1);
    wr(0, 32'h3);
    repeat (6) @(negedge clk);
    rd(3, v); chk("R3 hold timer", v, 0);
    rd(2, v); chk("R3 hold prescale", v, 0);
    wr(0, 32'h0);
    repeat (6) @(negedge clk);
    rd(3, v); chk("R3 run clear", v, 0);

    // match with reset and toggle on channel 0 (R7, R8, R10)
    wr(7, 32'h1B);
    for (int m = 1; m < 5; m++) begin
      wr(8, 32'(m));
      for (int n = 0; n < 13; n++) begin
        int hits;
        restart(0);
        o0 = 32'(match_out[0]);
        wr(0, 32'h1);
        repeat (n) @(negedge clk);
        hits = (n >= m) ? (n - m) / (m + 1) + 1 : 0;
        rd(3, v); chk("R8 reset period", v, 32'(n % (m + 1)));
        chk("R10 toggle", 32'(match_out[0]), o0 ^ 32'(hits & 1));
        rd(6, v); chk("R7 match flag", v & 32'h1, 32'(n >= m));
      end
    end

    // flag enable off: no flag (R7)
    wr(7, 32'h1A);
    restart(0);
    wr(0, 32'h1);
    repeat (8) @(negedge clk);
    rd(6, v); chk("R7 flag disabled", v, 0);

    // stop on match, channel 1 (R9)
    wr(7, 32'h80);
    wr(8, 32'd100);
    wr(9, 32'd3);
    for (int p = 0; p < 3; p++) begin
      restart(p);
      wr(0, 32'h1);
      repeat (3 * (p + 1) + 6) @(negedge clk);
      rd(3, v); chk("R9 stop value", v, 3);
      rd(2, v); chk("R9 stop prescale", v, 0);
      rd(0, v); chk("R9 run cleared", v & 32'h1, 0);
    end

    // output actions on channels 2 and 3 (R10)
    wr(9, 32'd100);
    wr(10, 32'd2);
    wr(11, 32'd2);
    wr(7, 32'(2 << 13));
    restart(0);
    wr(0, 32'h1);
    repeat (4) @(negedge clk);
    chk("R10 drive high", 32'(match_out[2]), 1);
    chk("R10 keep", 32'(match_out[3]), 0);
    wr(7, 32'((1 << 13) | (2 << 18)));
    restart(0);
    wr(0, 32'h1);
    repeat (4) @(negedge clk);
    chk("R10 drive low", 32'(match_out[2]), 0);
    chk("R10 drive high ch3", 32'(match_out[3]), 1);
    wr(7, 32'h0);

    // capture on rising edge, no clear (R5)
    wr(4, 32'h5);
    for (int g = 0; g < 6; g++) begin
      restart(0);
      wr(0, 32'h1);
      repeat (g) @(negedge clk);
      pulse(4, 4);
      rd(5, v); chk("R5 capture value", v, 32'(g + 2));
      rd(6, v); chk("R5 capture flag", v, 32'h10);
      chk("R11 irq from capture", 32'(irq), 1);
    end

    // write-1-to-clear (R11)
    wr(6, 32'h1);
    rd(6, v); chk("R11 other bit kept", v, 32'h10);
    wr(6, 32'h10);
    rd(6, v); chk("R11 cleared", v, 0);
    chk("R11 irq low", 32'(irq), 0);

    // pulse width: clear on rise, capture on fall (R6)
    wr(4, 32'h8 | 32'h2);
    for (int w = 2; w <= 10; w++) begin
      restart(0);
      wr(0, 32'h1);
      repeat (3) @(negedge clk);
      pulse(w, 6);
      rd(5, v); chk("R6 pulse width", v, 32'(w - 1));
    end

    // counter mode, every edge selection (R4)
    wr(4, 32'h0);
    for (int sel = 1; sel < 4; sel++)
      for (int k = 1; k < 6; k++) begin
        restart(0);
        wr(0, 32'(1 | 4 | (sel << 3)));
        for (int j = 0; j < k; j++) pulse(3, 3);
        repeat (4) @(negedge clk);
        rd(3, v); chk("R4 edge count", v, 32'((sel == 3) ? 2 * k : k));
      end
    for (int k = 1; k < 7; k++) begin
      restart(1);
      wr(0, 32'(1 | 4 | (1 << 3)));
      for (int j = 0; j < k; j++) pulse(3, 3);
      repeat (4) @(negedge clk);
      rd(3, v); chk("R4 prescaled edges", v, 32'(k / 2));
    end

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule